// File: doc/BRIEF.md
# Store-Multiple Push Sequencer

This block executes one decoded push-multiple instruction as a serial run of stack writes. A one-cycle `start` pulse presents the instruction fields and the current stack pointer. The fields are a lower and an upper register bound, a flag to save the link register, a flag to save the global pointer, and a flag to write a stack guard word. The block captures all of these, together with the link register and global pointer values, in the start cycle. It then pushes up to four groups of 64-bit words, each group gated on its own: the link register, then the global pointer, then the register range, then the guard word.

Words leave on a valid/ready write port. `mem_valid` rises when a word is ready. The word, address and read index hold steady until a cycle in which `mem_ready` is also high. That cycle completes the transfer, and the next word (if any) is presented in the following cycle. Range registers are read through a combinational register-file port: the block drives `rf_idx` and takes `rf_data` in the same cycle. When the run ends, `done` pulses for one cycle and `sp_out` holds the lowered stack pointer.

Top module: `mpush_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_valid` are low.
- R2: Written words appear in the fixed order link register, global pointer, range registers, guard word. Any group whose condition is false is skipped.
- R3: Each of the link, global pointer and guard words is written exactly when its own flag was set at start.
- R4: When upper bound >= lower bound, registers lower..upper are written in ascending index order. For each, `rf_idx` carries the index while `mem_data` carries `rf_data` of that cycle.
- R5: When upper bound < lower bound, no range register is written.
- R6: The guard word equals 64'h5A3C_96E1_0F78_C3A5 XOR the stack pointer given at start.
- R7: The k-th word (k from 1) is written to address `sp_in - 8*k`. After a run of n words, `sp_out = sp_in - 8*n`.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` stays unchanged in the next cycle.
- R9: With no flag set and an empty range, `done` is high in the cycle after start, no write is issued and `sp_out` equals `sp_in`.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle. A `start` while busy is ignored.
- R11: `done` is a single-cycle pulse, high in the cycle after the final accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a push run (accepted only when not busy) |
| hi_idx | input | 6 | Upper register bound |
| lo_idx | input | 6 | Lower register bound |
| save_link | input | 1 | Push the link register |
| save_gp | input | 1 | Push the global pointer |
| emit_guard | input | 1 | Push the stack guard word |
| sp_in | input | 64 | Stack pointer at start |
| link_data | input | 64 | Link register value, captured at start |
| gp_data | input | 64 | Global pointer value, captured at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| sp_out | output | 64 | Current / final stack pointer |
| rf_idx | output | 6 | Register-file read index |
| rf_data | input | 64 | Register-file read data for `rf_idx` |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Write byte address |
| mem_data | output | 64 | Write data |

## Verification
The first write is presented in the cycle after the start edge. Each later write is presented in the cycle after the previous accepted handshake, and `done` follows one cycle after the last handshake. An empty run shows `done` exactly one cycle after start. The bench logs the clock edge of every handshake, of the start and of `done`, and compares `done` against the last handshake edge plus one (or the start edge plus one). Outputs are read at the falling edge, half a cycle after the registers settle, and `mem_ready` is toggled there in stall runs so that each presented word waits a known number of cycles.

// File: rtl/mpush_pkg.sv
package mpush_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LINK  = 3'd1,
    PH_GP    = 3'd2,
    PH_RANGE = 3'd3,
    PH_GUARD = 3'd4,
    PH_FIN   = 3'd5
  } phase_e;
endpackage

// File: rtl/mpush_order.sv
// Picks the first enabled push stage at or after a given stage.
module mpush_order
  import mpush_pkg::*;
(
  input  phase_e from_ph,
  input  logic   want_link,
  input  logic   want_gp,
  input  logic   want_range,
  input  logic   want_guard,
  output phase_e next_ph
);
  always_comb begin
    if (from_ph <= PH_LINK && want_link)        next_ph = PH_LINK;
    else if (from_ph <= PH_GP && want_gp)       next_ph = PH_GP;
    else if (from_ph <= PH_RANGE && want_range) next_ph = PH_RANGE;
    else if (from_ph <= PH_GUARD && want_guard) next_ph = PH_GUARD;
    else                                        next_ph = PH_FIN;
  end
endmodule

// File: rtl/mpush_sp.sv
// Stack pointer register, write address and guard word.
module mpush_sp #(
  parameter int          AW      = 64,
  parameter int          WBYTES  = 8,
  parameter logic [63:0] MAGIC   = 64'h5A3C_96E1_0F78_C3A5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] sp_init,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] guard_q
);
  localparam logic [AW-1:0] STEP = AW'(WBYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      guard_q <= '0;
    end else if (load) begin
      sp_q    <= sp_init;
      guard_q <= MAGIC[AW-1:0] ^ sp_init;
    end else if (step) begin
      sp_q    <= sp_q - STEP;
    end
  end

  assign wr_addr = sp_q - STEP;
endmodule

// File: rtl/mpush_range.sv
// Ascending register-range index walker.
module mpush_range #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [IW-1:0] lo_in,
  input  logic [IW-1:0] hi_in,
  output logic [IW-1:0] idx,
  output logic          last
);
  logic [IW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      hi_q <= '0;
    end else if (load) begin
      idx  <= lo_in;
      hi_q <= hi_in;
    end else if (step && !last) begin
      idx  <= idx + 1'b1;
    end
  end

  assign last = (idx == hi_q);
endmodule

// File: rtl/mpush_seq.sv
module mpush_seq
  import mpush_pkg::*;
#(
  parameter int          AW     = 64,
  parameter int          DW     = 64,
  parameter int          IW     = 6,
  parameter int          WBYTES = DW / 8,
  parameter logic [63:0] MAGIC  = 64'h5A3C_96E1_0F78_C3A5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] hi_idx,
  input  logic [IW-1:0] lo_idx,
  input  logic          save_link,
  input  logic          save_gp,
  input  logic          emit_guard,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] link_data,
  input  logic [DW-1:0] gp_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] sp_out,
  output logic [IW-1:0] rf_idx,
  input  logic [DW-1:0] rf_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  phase_e        state_q, state_d, first_ph, adv_ph, succ_ph;
  logic          link_f, gp_f, range_f, guard_f;
  logic [DW-1:0] link_q, gp_q;
  logic [AW-1:0] guard_w;
  logic          accept, fire, rng_last, range_ok;

  assign accept   = start && (state_q == PH_IDLE);
  assign fire     = mem_valid && mem_ready;
  assign range_ok = (hi_idx >= lo_idx);
  assign succ_ph  = phase_e'(state_q + 3'd1);

  mpush_order u_first (
    .from_ph(PH_LINK), .want_link(save_link), .want_gp(save_gp),
    .want_range(range_ok), .want_guard(emit_guard), .next_ph(first_ph)
  );

  mpush_order u_adv (
    .from_ph(succ_ph), .want_link(link_f), .want_gp(gp_f),
    .want_range(range_f), .want_guard(guard_f), .next_ph(adv_ph)
  );

  mpush_sp #(.AW(AW), .WBYTES(WBYTES), .MAGIC(MAGIC)) u_sp (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(fire),
    .sp_init(sp_in), .sp_q(sp_out), .wr_addr(mem_addr), .guard_q(guard_w)
  );

  mpush_range #(.IW(IW)) u_rng (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .step(fire && state_q == PH_RANGE),
    .lo_in(lo_idx), .hi_in(hi_idx), .idx(rf_idx), .last(rng_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      link_f  <= 1'b0;
      gp_f    <= 1'b0;
      range_f <= 1'b0;
      guard_f <= 1'b0;
      link_q  <= '0;
      gp_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        link_f  <= save_link;
        gp_f    <= save_gp;
        range_f <= range_ok;
        guard_f <= emit_guard;
        link_q  <= link_data;
        gp_q    <= gp_data;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE:  if (accept) state_d = first_ph;
      PH_LINK,
      PH_GP,
      PH_GUARD: if (fire) state_d = adv_ph;
      PH_RANGE: if (fire && rng_last) state_d = adv_ph;
      PH_FIN:   state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  always_comb begin
    case (state_q)
      PH_LINK:  mem_data = link_q;
      PH_GP:    mem_data = gp_q;
      PH_RANGE: mem_data = rf_data;
      PH_GUARD: mem_data = DW'(guard_w);
      default:  mem_data = '0;
    endcase
  end

  assign mem_valid = (state_q == PH_LINK) || (state_q == PH_GP) ||
                     (state_q == PH_RANGE) || (state_q == PH_GUARD);
  assign busy      = (state_q != PH_IDLE);
  assign done      = (state_q == PH_FIN);
endmodule

// File: rtl/mpush_seq_chk.sv
module mpush_seq_chk #(
  parameter int AW = 64,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] sp_out,
  input logic [IW-1:0] rf_idx,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr
);
  // R1: no write request outside a run
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  // R8: a stalled request holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(rf_idx)));

  // R7: an accepted write lowers the pointer to that write's address
  p_sp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (sp_out == $past(mem_addr)));

  // R10: an accepted start makes the block busy
  p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R11: done lasts one cycle and ends the run
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R11: done never overlaps a write request
  p_done_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid);
endmodule

bind mpush_seq mpush_seq_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sp_out(sp_out), .rf_idx(rf_idx), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/mpush_seq_bench.sv
module mpush_seq_bench;
  localparam logic [63:0] MAGIC = 64'h5A3C_96E1_0F78_C3A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  hi_idx = '0, lo_idx = '0;
  logic        save_link = 1'b0, save_gp = 1'b0, emit_guard = 1'b0;
  logic [63:0] sp_in = '0;
  logic [63:0] link_data = 64'h1111_2222_3333_4444;
  logic [63:0] gp_data   = 64'h5555_6666_7777_8888;
  logic        busy, done, mem_valid;
  logic        mem_ready = 1'b1;
  logic [63:0] sp_out, rf_data, mem_addr, mem_data;
  logic [5:0]  rf_idx;

  int checks = 0, fails = 0, cyc = 0;
  int cap_n = 0, done_n = 0, done_cyc = 0, last_fire = 0, start_cyc = 0, stall_err = 0;
  logic stall_mode = 1'b0, finished = 1'b0;
  logic prev_stall = 1'b0;
  logic [63:0] prev_addr = '0;
  logic [63:0] cap_a [0:127];
  logic [63:0] cap_d [0:127];
  logic [63:0] exp_d [0:127];

  always #10 clk = ~clk;

  assign rf_data = {32'hC0DE_0000, 26'd0, rf_idx};

  mpush_seq u_mpush_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .hi_idx(hi_idx), .lo_idx(lo_idx),
    .save_link(save_link), .save_gp(save_gp), .emit_guard(emit_guard),
    .sp_in(sp_in), .link_data(link_data), .gp_data(gp_data),
    .busy(busy), .done(done), .sp_out(sp_out), .rf_idx(rf_idx), .rf_data(rf_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (prev_stall && !(mem_valid && mem_addr == prev_addr)) stall_err = stall_err + 1;
    prev_stall = mem_valid && !mem_ready;
    prev_addr  = mem_addr;
    if (mem_valid && mem_ready) begin
      if (cap_n < 128) begin
        cap_a[cap_n] = mem_addr;
        cap_d[cap_n] = mem_data;
      end
      cap_n = cap_n + 1;
      last_fire = cyc;
    end
    if (done) begin
      done_n = done_n + 1;
      done_cyc = cyc;
    end
    if (start && !busy) start_cyc = cyc;
  end

  always @(negedge clk) mem_ready <= stall_mode ? (cyc % 3 != 0) : 1'b1;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Runs one push instruction and checks every word, address, pointer and timing.
  task automatic run_case(input logic [5:0] hi, input logic [5:0] lo, input logic l,
                          input logic g, input logic c, input logic [63:0] sp,
                          input logic stall, input logic poke);
    int n = 0;
    int guard = 0;
    if (l) begin exp_d[n] = link_data; n++; end
    if (g) begin exp_d[n] = gp_data; n++; end
    if (hi >= lo)
      for (int i = int'(lo); i <= int'(hi); i++) begin
        exp_d[n] = {32'hC0DE_0000, 26'd0, 6'(i)}; n++;
      end
    if (c) begin exp_d[n] = MAGIC ^ sp; n++; end
    cap_n = 0; done_n = 0; stall_err = 0; stall_mode = stall;
    @(negedge clk);
    hi_idx = hi; lo_idx = lo; save_link = l; save_gp = g; emit_guard = c; sp_in = sp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; hi_idx = hi ^ 6'h15; sp_in = ~sp; save_link = ~l; emit_guard = ~c;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_n == 0 && guard < 1000) begin
      @(posedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(done_n == 1, "R11 single done pulse", 64'(done_n), 64'd1);
    chk(busy == 1'b0, "R10 idle after done", 64'(busy), 64'd0);
    chk(cap_n == n, "R2 write count", 64'(cap_n), 64'(n));
    for (int k = 0; k < n && k < cap_n; k++) begin
      chk(cap_d[k] == exp_d[k], "R2/R3/R4/R6 word data", cap_d[k], exp_d[k]);
      chk(cap_a[k] == sp - 64'(8 * (k + 1)), "R7 word address", cap_a[k], sp - 64'(8 * (k + 1)));
    end
    chk(sp_out == sp - 64'(8 * n), "R7 final pointer", sp_out, sp - 64'(8 * n));
    if (n > 0) chk(done_cyc == last_fire + 1, "R11 done timing", 64'(done_cyc), 64'(last_fire + 1));
    else       chk(done_cyc == start_cyc + 1, "R9 empty done timing", 64'(done_cyc), 64'(start_cyc + 1));
    chk(stall_err == 0, "R8 stalled request held", 64'(stall_err), 64'd0);
    stall_mode = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy at reset", 64'(busy), 64'd0);
    chk(done == 1'b0, "R1 done at reset", 64'(done), 64'd0);
    chk(mem_valid == 1'b0, "R1 mem_valid at reset", 64'(mem_valid), 64'd0);
  endtask

  task automatic t_all_groups();   run_case(6'd12, 6'd9, 1, 1, 1, 64'h0000_8000_0000_1000, 0, 0); endtask
  task automatic t_range_only();   run_case(6'd5, 6'd0, 0, 0, 0, 64'h2000, 0, 0); endtask
  task automatic t_flags_no_range(); run_case(6'd3, 6'd7, 1, 0, 1, 64'h3000, 0, 0); endtask   // R5
  task automatic t_gp_single();    run_case(6'd40, 6'd40, 0, 1, 0, 64'h4008, 0, 0); endtask   // R4 one register
  task automatic t_empty();        run_case(6'd1, 6'd2, 0, 0, 0, 64'h5000, 0, 0); endtask     // R9
  task automatic t_stall();        run_case(6'd63, 6'd58, 1, 1, 1, 64'hFFFF_0000, 1, 0); endtask // R8
  task automatic t_start_ignored(); run_case(6'd20, 6'd16, 1, 0, 1, 64'h6000, 1, 1); endtask // R10
  task automatic t_full_range();   run_case(6'd63, 6'd0, 0, 0, 1, 64'h0001_0000, 0, 0); endtask
  task automatic t_guard_only();   run_case(6'd0, 6'd1, 0, 0, 1, 64'hDEAD_BEEF_0000_0040, 0, 0); endtask // R6

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    fails = fails + 1;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_all_groups();
    t_range_only();
    t_flags_no_range();
    t_gp_single();
    t_empty();
    t_stall();
    t_start_ignored();
    t_full_range();
    t_guard_only();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule